// File: doc/BRIEF.md
# Overlapping Register Window File

This block is the integer register file of a RISC core that uses register windows. A procedure addresses a small architectural register space. The block translates each reference through a current window pointer into a larger circular physical buffer. Consecutive windows share a group of registers, so a caller puts arguments in its outgoing group and the callee finds them in its incoming group without any copy. Results travel back the same way. A set of global registers sits outside the windowing and is the same from every window.

Call and return pulses move the current window pointer. A saved window pointer marks the oldest window that is held in memory. A call whose next window would land on it raises an overflow trap. A return whose previous window is held in memory raises an underflow trap. While a trap is pending the current pointer stays still and further call or return pulses are ignored. A software handler does the spilling or filling. It then moves the saved pointer one step with a single-cycle pulse, which clears the trap, and retries the call or return.

Top module: `reg_window_file`

## Requirements
- R1: After synchronous reset the current pointer is 0 and the saved pointer is NWIN-1 (7). Both traps are low, and every architectural register reads zero.
- R2: Architectural register 0 always reads zero, and a write to it has no effect.
- R3: Architectural addresses have the group in bits [4:3] and the index in bits [2:0]. Group 00 selects a global register, which holds the same storage whatever the current pointer is.
- R4: Group 01 selects the incoming group of the current window and group 11 selects the outgoing group. Outgoing register k of window w is the same storage as incoming register k of window (w+1) mod NWIN.
- R5: Group 10 selects the local group, which is private to each window. A value written there is still present when the pointer comes back to that window.
- R6: A call pulse moves the current pointer to (cwp+1) mod NWIN and a return pulse moves it to (cwp-1) mod NWIN. The change is visible in the cycle after the pulse.
- R7: A call with (cwp+1) mod NWIN equal to the saved pointer sets the overflow trap instead of moving the pointer.
- R8: A return with (cwp-1) mod NWIN equal to the saved pointer sets the underflow trap instead of moving the pointer.
- R9: While either trap is set, call and return pulses are ignored. An advance pulse adds one to the saved pointer and a retreat pulse subtracts one. Either pulse alone clears both traps. If both pulses are high in the same cycle, they do nothing.
- R10: When a register is written and read in the same cycle, the read returns the old value. The new value is read from the next cycle on.
- R11: Call and return high in the same cycle leave the current pointer and the traps unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raddr_a | input | 5 | Read port A architectural address |
| rdata_a | output | 32 | Read port A data (combinational) |
| raddr_b | input | 5 | Read port B architectural address |
| rdata_b | output | 32 | Read port B data (combinational) |
| we | input | 1 | Write enable |
| waddr | input | 5 | Write architectural address |
| wdata | input | 32 | Write data |
| call | input | 1 | Procedure call pulse |
| ret | input | 1 | Procedure return pulse |
| swp_inc | input | 1 | Handler pulse: advance saved pointer |
| swp_dec | input | 1 | Handler pulse: retreat saved pointer |
| cwp | output | 3 | Current window pointer |
| swp | output | 3 | Saved window pointer |
| ovf_trap | output | 1 | Overflow trap pending |
| unf_trap | output | 1 | Underflow trap pending |

## Verification
The hardest cases to reach are the wrap of the window pointer past NWIN-1 and the outgoing group of the highest window aliasing the incoming group of window 0. Both need a full chain of calls, and each blocked call must be cleared by a handler pulse before the chain can go on. The stimulus calls from window 0 to the overflow and clears it with an advance pulse. It then goes on through window 7 and back to window 0, clearing a second overflow on the way. At every window it fills all registers with values that encode the window and address, and it reads back the full space on both ports. It then returns all the way down to force two underflows, so that locals retained across the wrap and the overwritten aliased group are both checked against an arithmetic model.

// File: rtl/rw_pkg.sv
package rw_pkg;

    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'b00,
        GRP_IN     = 2'b01,
        GRP_LOCAL  = 2'b10,
        GRP_OUT    = 2'b11
    } grp_e;

    typedef struct packed {
        logic call;
        logic ret;
        logic swp_inc;
        logic swp_dec;
    } ptr_cmd_t;

    function automatic grp_e grp_of(input logic [1:0] top_bits);
        return grp_e'(top_bits);
    endfunction

endpackage

// File: rtl/rw_ptr_ctrl.sv
module rw_ptr_ctrl
    import rw_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int WW = $clog2(NWIN)
) (
    input  logic          clk,
    input  logic          rst,
    input  ptr_cmd_t      cmd,
    output logic [WW-1:0] cwp,
    output logic [WW-1:0] swp,
    output logic          ovf,
    output logic          unf
);

    logic [WW-1:0] cwp_nx;
    logic [WW-1:0] cwp_pv;
    logic          pending;
    logic          fwd;
    logic          bwd;
    logic          adj;

    always_comb begin
        cwp_nx  = cwp + WW'(1);
        cwp_pv  = cwp - WW'(1);
        pending = ovf | unf;
        fwd     = cmd.call & ~cmd.ret & ~pending;
        bwd     = cmd.ret & ~cmd.call & ~pending;
        adj     = cmd.swp_inc ^ cmd.swp_dec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp <= '0;
            swp <= WW'(NWIN - 1);
            ovf <= 1'b0;
            unf <= 1'b0;
        end else begin
            if (adj) begin
                swp <= cmd.swp_inc ? swp + WW'(1) : swp - WW'(1);
                ovf <= 1'b0;
                unf <= 1'b0;
            end
            if (fwd) begin
                if (cwp_nx == swp) ovf <= 1'b1;
                else               cwp <= cwp_nx;
            end
            if (bwd) begin
                if (cwp_pv == swp) unf <= 1'b1;
                else               cwp <= cwp_pv;
            end
        end
    end

endmodule

// File: rtl/rw_bank.sv
module rw_bank
    import rw_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int NREG = 8,
    parameter int DW   = 32,
    parameter int NRD  = 2,
    localparam int WW  = $clog2(NWIN),
    localparam int IW  = $clog2(NREG),
    localparam int AW  = IW + 2,
    localparam int NPHY = NWIN * 2 * NREG,
    localparam int PW  = $clog2(NPHY)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [WW-1:0] cwp,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr [NRD],
    output logic [DW-1:0] rdata [NRD]
);

    logic [DW-1:0] wmem [NPHY];
    logic [DW-1:0] glb  [NREG];

    // windowed physical index: {window, local-select, index}
    function automatic logic [PW-1:0] phys_of(input logic [AW-1:0] a,
                                              input logic [WW-1:0] w);
        grp_e          g;
        logic [WW-1:0] win;
        g   = grp_of(a[AW-1 -: 2]);
        win = (g == GRP_OUT) ? w + WW'(1) : w;
        return {win, (g == GRP_LOCAL), a[IW-1:0]};
    endfunction

    logic          w_glob;
    logic          w_zero;
    logic [PW-1:0] w_phys;

    always_comb begin
        w_glob = (grp_of(waddr[AW-1 -: 2]) == GRP_GLOBAL);
        w_zero = w_glob && (waddr[IW-1:0] == '0);
        w_phys = phys_of(waddr, cwp);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPHY; i++) wmem[i] <= '0;
            for (int i = 0; i < NREG; i++) glb[i]  <= '0;
        end else if (we && !w_zero) begin
            if (w_glob) glb[waddr[IW-1:0]] <= wdata;
            else        wmem[w_phys]       <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (grp_of(raddr[p][AW-1 -: 2]) == GRP_GLOBAL) begin
                rdata[p] = (raddr[p][IW-1:0] == '0) ? '0 : glb[raddr[p][IW-1:0]];
            end else begin
                rdata[p] = wmem[phys_of(raddr[p], cwp)];
            end
        end
    end

endmodule

// File: rtl/reg_window_file.sv
module reg_window_file
    import rw_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int NREG = 8,
    parameter int DW   = 32,
    localparam int WW  = $clog2(NWIN),
    localparam int AW  = $clog2(NREG) + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          call,
    input  logic          ret,
    input  logic          swp_inc,
    input  logic          swp_dec,
    output logic [WW-1:0] cwp,
    output logic [WW-1:0] swp,
    output logic          ovf_trap,
    output logic          unf_trap
);

    ptr_cmd_t      cmd;
    logic [AW-1:0] rd_addr [2];
    logic [DW-1:0] rd_data [2];

    always_comb begin
        cmd.call    = call;
        cmd.ret     = ret;
        cmd.swp_inc = swp_inc;
        cmd.swp_dec = swp_dec;
        rd_addr[0]  = raddr_a;
        rd_addr[1]  = raddr_b;
        rdata_a     = rd_data[0];
        rdata_b     = rd_data[1];
    end

    rw_ptr_ctrl #(.NWIN(NWIN)) u_ptr (
        .clk (clk),
        .rst (rst),
        .cmd (cmd),
        .cwp (cwp),
        .swp (swp),
        .ovf (ovf_trap),
        .unf (unf_trap)
    );

    rw_bank #(.NWIN(NWIN), .NREG(NREG), .DW(DW), .NRD(2)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .cwp   (cwp),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

endmodule

// File: rtl/reg_window_file_chk.sv
module reg_window_file_chk #(
    parameter int WW = 3,
    parameter int AW = 5,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          call,
    input logic          ret,
    input logic [WW-1:0] cwp,
    input logic [WW-1:0] swp,
    input logic          ovf_trap,
    input logic          unf_trap,
    input logic [AW-1:0] raddr_a,
    input logic [DW-1:0] rdata_a
);

    logic [WW-1:0] cwp_nx;
    logic [WW-1:0] cwp_pv;
    assign cwp_nx = cwp + WW'(1);
    assign cwp_pv = cwp - WW'(1);

    // R2: register 0 reads zero
    a_r2_zero_reg: assert property (@(posedge clk) disable iff (rst)
        (raddr_a == '0) |-> (rdata_a == '0));

    // R6: pointer moves by at most one window per cycle
    a_r6_cwp_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cwp == $past(cwp)) || (cwp == $past(cwp_nx)) || (cwp == $past(cwp_pv)));

    // R7: overflow only from a colliding call
    a_r7_ovf_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_trap) |-> ($past(call) && ($past(cwp_nx) == $past(swp))));

    // R8: underflow only from a colliding return
    a_r8_unf_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(unf_trap) |-> ($past(ret) && ($past(cwp_pv) == $past(swp))));

    // R9: pointer frozen while a trap is pending
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (ovf_trap || unf_trap) |=> (cwp == $past(cwp)));

    // R7: traps never both pending
    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ovf_trap && unf_trap));

endmodule

bind reg_window_file reg_window_file_chk #(.WW(WW), .AW(AW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .call     (call),
    .ret      (ret),
    .cwp      (cwp),
    .swp      (swp),
    .ovf_trap (ovf_trap),
    .unf_trap (unf_trap),
    .raddr_a  (raddr_a),
    .rdata_a  (rdata_a)
);

// File: tb/reg_window_file_tb.sv
module reg_window_file_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  raddr_a = '0, raddr_b = '0, waddr = '0;
    logic [31:0] rdata_a, rdata_b, wdata = '0;
    logic        we = 1'b0, call = 1'b0, ret = 1'b0, swp_inc = 1'b0, swp_dec = 1'b0;
    logic [2:0]  cwp, swp;
    logic        ovf_trap, unf_trap;

    int n_vec = 0;
    int n_bad = 0;

    // bench model
    logic [31:0] mw [128];
    logic [31:0] mg [8];
    logic [2:0]  m_cwp, m_swp;
    logic        m_ovf, m_unf;

    always #10 clk = ~clk;

    reg_window_file u_dut (
        .clk(clk), .rst(rst),
        .raddr_a(raddr_a), .rdata_a(rdata_a),
        .raddr_b(raddr_b), .rdata_b(rdata_b),
        .we(we), .waddr(waddr), .wdata(wdata),
        .call(call), .ret(ret), .swp_inc(swp_inc), .swp_dec(swp_dec),
        .cwp(cwp), .swp(swp), .ovf_trap(ovf_trap), .unf_trap(unf_trap)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // windowed index from R4/R5: window*16 + local*8 + index; outgoing uses window+1
    function automatic int widx(input logic [2:0] w, input logic [4:0] a);
        logic [2:0] win;
        win = (a[4:3] == 2'b11) ? w + 3'd1 : w;
        return int'(win) * 16 + ((a[4:3] == 2'b10) ? 8 : 0) + int'(a[2:0]);
    endfunction

    function automatic logic [31:0] expv(input logic [4:0] a);
        if (a[4:3] == 2'b00) return (a[2:0] == 3'd0) ? 32'h0 : mg[a[2:0]];
        return mw[widx(m_cwp, a)];
    endfunction

    function automatic string tag_of(input logic [4:0] a);
        if (a == 5'd0)         return "R2";
        if (a[4:3] == 2'b00)   return "R3";
        if (a[4:3] == 2'b10)   return "R5";
        return "R4";
    endfunction

    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        we = 1'b1; waddr = a; wdata = v;
        tick();
        we = 1'b0;
        if (a[4:3] == 2'b00) begin
            if (a[2:0] != 3'd0) mg[a[2:0]] = v;
        end else begin
            mw[widx(m_cwp, a)] = v;
        end
    endtask

    task automatic rd_all();
        for (int a = 0; a < 32; a++) begin
            raddr_a = 5'(a);
            raddr_b = 5'(31 - a);
            #1;
            chk(tag_of(5'(a)), rdata_a, expv(5'(a)));
            chk(tag_of(5'(31 - a)), rdata_b, expv(5'(31 - a)));
        end
    endtask

    task automatic ptr(input string tag, input logic c, input logic r,
                       input logic inc, input logic dec);
        logic [2:0] oc, os;
        logic       pend;
        oc = m_cwp; os = m_swp; pend = m_ovf | m_unf;
        call = c; ret = r; swp_inc = inc; swp_dec = dec;
        tick();
        call = 1'b0; ret = 1'b0; swp_inc = 1'b0; swp_dec = 1'b0;
        if (inc != dec) begin
            m_swp = inc ? os + 3'd1 : os - 3'd1;
            m_ovf = 1'b0; m_unf = 1'b0;
        end
        if ((c != r) && !pend) begin
            if (c) begin
                if (3'(oc + 3'd1) == os) m_ovf = 1'b1; else m_cwp = oc + 3'd1;
            end else begin
                if (3'(oc - 3'd1) == os) m_unf = 1'b1; else m_cwp = oc - 3'd1;
            end
        end
        chk(tag, 32'(cwp), 32'(m_cwp));
        chk(tag, 32'(swp), 32'(m_swp));
        chk(tag, 32'(ovf_trap), 32'(m_ovf));
        chk(tag, 32'(unf_trap), 32'(m_unf));
    endtask

    task automatic fill(input int pass);
        for (int a = 8; a < 32; a++)
            wr(5'(a), 32'h5000_0000 | (32'(pass) << 16) | (32'(m_cwp) << 8) | 32'(a));
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) mw[i] = '0;
        for (int i = 0; i < 8; i++)   mg[i] = '0;
        m_cwp = 3'd0; m_swp = 3'd7; m_ovf = 1'b0; m_unf = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1", 32'(cwp), 32'd0);
        chk("R1", 32'(swp), 32'd7);
        chk("R1", 32'(ovf_trap), 32'd0);
        chk("R1", 32'(unf_trap), 32'd0);
        for (int a = 0; a < 32; a++) begin
            raddr_a = 5'(a); #1;
            chk("R1", rdata_a, 32'h0);
        end
        // R2 write to register 0 ignored
        wr(5'd0, 32'hDEAD_BEEF);
        raddr_a = 5'd0; #1;
        chk("R2", rdata_a, 32'h0);
        // R10 same-cycle write and read
        raddr_a = 5'd9; we = 1'b1; waddr = 5'd9; wdata = 32'h1234_5678; #1;
        chk("R10", rdata_a, 32'h0);
        tick();
        we = 1'b0; mw[widx(m_cwp, 5'd9)] = 32'h1234_5678; #1;
        chk("R10", rdata_a, 32'h1234_5678);
        // R3 globals
        for (int g = 1; g < 8; g++) wr(5'(g), 32'hA000_0000 + 32'(g));
        // climb windows 0..6; last call overflows (R7)
        for (int w = 0; w < 7; w++) begin
            rd_all();
            fill(1);
            rd_all();
            ptr((w == 6) ? "R7" : "R6", 1'b1, 1'b0, 1'b0, 1'b0);
        end
        ptr("R9", 1'b1, 1'b0, 1'b0, 1'b0);
        ptr("R9", 1'b0, 1'b1, 1'b0, 1'b0);
        ptr("R9", 1'b0, 1'b0, 1'b1, 1'b0);
        ptr("R6", 1'b1, 1'b0, 1'b0, 1'b0);
        rd_all();
        fill(2);
        rd_all();
        ptr("R7", 1'b1, 1'b0, 1'b0, 1'b0);
        ptr("R9", 1'b0, 1'b0, 1'b1, 1'b0);
        ptr("R6", 1'b1, 1'b0, 1'b0, 1'b0);
        rd_all();
        // R11 simultaneous call and return
        ptr("R11", 1'b1, 1'b1, 1'b0, 1'b0);
        // descend: 0 -> 7 -> ... -> 2, checking retained locals
        for (int k = 0; k < 6; k++) begin
            ptr("R6", 1'b0, 1'b1, 1'b0, 1'b0);
            rd_all();
        end
        ptr("R8", 1'b0, 1'b1, 1'b0, 1'b0);
        ptr("R9", 1'b0, 1'b0, 1'b0, 1'b1);
        ptr("R6", 1'b0, 1'b1, 1'b0, 1'b0);
        rd_all();
        ptr("R8", 1'b0, 1'b1, 1'b0, 1'b0);
        ptr("R9", 1'b0, 1'b0, 1'b1, 1'b1);
        ptr("R9", 1'b0, 1'b0, 1'b0, 1'b1);
        ptr("R6", 1'b0, 1'b1, 1'b0, 1'b0);
        rd_all();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule